// File: doc/BRIEF.md
# Touch-Probe Phase Capture Register

The block integrates a signed speed value into a running phase position. Each valid speed sample is sign-extended and added to a wrapping two's-complement accumulator. The accumulator value is always driven on an output, so downstream logic can read the live phase at any time.

An external touch-probe pin freezes the phase at an event. A rising edge on the probe pin copies the accumulator into a "latest capture" register. The value that register held before moves into a "previous capture" register, so the block keeps a two-deep history. After each capture an inhibit flag goes high, and further probe edges are ignored while it is set. Only a fresh rising edge on a separate re-arm input clears the flag; holding the re-arm input high has no further effect.

Both pins are asynchronous to the clock, so each passes through a two-flop synchroniser before its edge is detected. A synchronous function-clear input returns the accumulator, both captures and the inhibit flag to zero. It takes priority over every other action.

Top module: `tp_phase_latch`

## Requirements
- R1: When `spd_vld` is high, the accumulator adds `spd_in` (16-bit signed, sign-extended) at the clock edge and wraps modulo 2^32. When `spd_vld` is low, the accumulator holds its value whatever `spd_in` carries.
- R2: `phase_o` always shows the accumulator register, one clock after the sample that changed it.
- R3: A rising edge on `probe_in` is captured at the third rising clock edge after the pin goes high (two synchroniser flops plus the capture register). `cap_last_o` then takes the accumulator value from before that edge's addition.
- R4: On every accepted capture, `cap_prev_o` takes the value `cap_last_o` held just before.
- R5: An accepted capture sets `inhibit_o`. While it is high, probe edges leave both capture outputs unchanged.
- R6: `inhibit_o` is cleared by a synchronised rising edge on `rearm_in`, seen on the same third clock edge. A steady high on `rearm_in` does not clear a later inhibit.
- R7: If probe and re-arm edges are detected in the same cycle, the re-arm wins. The flag ends low, the capture registers are unchanged, and the next probe edge is the one that captures.
- R8: While `func_clr` is high, the accumulator, both captures and the inhibit flag are cleared at each clock edge. The clear overrides accumulation, capture and re-arm.
- R9: After `rst_n` is released, every output reads zero and the block is armed, with `inhibit_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_clr | input | 1 | Synchronous clear of all function state |
| spd_in | input | 16 | Signed speed sample |
| spd_vld | input | 1 | Speed sample valid strobe |
| probe_in | input | 1 | Asynchronous touch-probe pin |
| rearm_in | input | 1 | Asynchronous re-arm pin (rising edge active) |
| phase_o | output | 32 | Live accumulated phase |
| cap_last_o | output | 32 | Most recent captured phase |
| cap_prev_o | output | 32 | Capture before the most recent one |
| inhibit_o | output | 1 | High once a capture has occurred, until re-armed |

## Verification
The assertions assume the pins stay at each level for at least two clock cycles. That lets every transition pass cleanly through the synchronisers and produce exactly one edge pulse. The bench drives the pins on the falling clock edge and holds each level for three or more cycles. The bench also keeps `spd_vld` low around probe events, except where a test overlaps a clear with accumulation on purpose. This keeps the expected captured phase unambiguous.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int TP_ACC_W  = 32;
    localparam int TP_SPD_W  = 16;
    localparam int TP_SYNC_N = 2;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_REARM   = 2'd2,
        ACT_CLEAR   = 2'd3
    } hist_act_e;

    // Priority: clear, then re-arm, then an armed capture.
    function automatic hist_act_e pick_action(
        input logic clr,
        input logic rearm_rise,
        input logic probe_rise,
        input logic inhibited
    );
        if (clr)                           return ACT_CLEAR;
        else if (rearm_rise)               return ACT_REARM;
        else if (probe_rise && !inhibited) return ACT_CAPTURE;
        else                               return ACT_NONE;
    endfunction

endpackage

// File: rtl/tp_edge_sync.sv
module tp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    // Synchroniser flops plus one history flop for edge detection.
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // A detected edge lasts exactly one cycle (supports R3 and R6).
    assert_rise_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tp_phase_acc.sv
module tp_phase_acc #(
    parameter int SPD_W = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SPD_W-1:0] spd_i,
    input  logic             vld_i,
    output logic [ACC_W-1:0] acc_o
);

    localparam int EXT_W = ACC_W - SPD_W;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] spd_ext;

    assign spd_ext = {{EXT_W{spd_i[SPD_W-1]}}, spd_i};

    always_comb begin
        acc_d = acc_q;
        if (clr_i)      acc_d = '0;
        else if (vld_i) acc_d = acc_q + spd_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    assert_acc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clr_i) |=> acc_o == $past(acc_o) + {{EXT_W{$past(spd_i[SPD_W-1])}}, $past(spd_i)});

    assert_acc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !clr_i) |=> $stable(acc_o));

    assert_acc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_o == '0);

endmodule

// File: rtl/tp_cap_hist.sv
module tp_cap_hist
    import tp_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             probe_rise_i,
    input  logic             rearm_rise_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] last_o,
    output logic [ACC_W-1:0] prev_o,
    output logic             inhibit_o
);

    typedef struct packed {
        logic [ACC_W-1:0] last;
        logic [ACC_W-1:0] prev;
        logic             inh;
    } hist_t;

    hist_t     st_d, st_q;
    hist_act_e act;

    always_comb begin
        act  = pick_action(clr_i, rearm_rise_i, probe_rise_i, st_q.inh);
        st_d = st_q;
        unique case (act)
            ACT_CLEAR: st_d = '0;
            ACT_REARM: st_d.inh = 1'b0;
            ACT_CAPTURE: begin
                st_d.prev = st_q.last;
                st_d.last = acc_i;
                st_d.inh  = 1'b1;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_o    = st_q.last;
    assign prev_o    = st_q.prev;
    assign inhibit_o = st_q.inh;

    assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !rearm_rise_i && probe_rise_i && !inhibit_o) |=> last_o == $past(acc_i));

    assert_history_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !rearm_rise_i && probe_rise_i && !inhibit_o) |=> prev_o == $past(last_o));

    assert_inhibit_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !rearm_rise_i && inhibit_o) |=> inhibit_o && $stable(last_o) && $stable(prev_o));

    assert_rearm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && rearm_rise_i) |=> !inhibit_o);

    assert_coincident_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && rearm_rise_i && probe_rise_i) |=> $stable(last_o) && $stable(prev_o));

    assert_hist_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (last_o == '0) && (prev_o == '0) && !inhibit_o);

endmodule

// File: rtl/tp_phase_latch.sv
module tp_phase_latch
    import tp_pkg::*;
#(
    parameter int SPD_W  = TP_SPD_W,
    parameter int ACC_W  = TP_ACC_W,
    parameter int SYNC_N = TP_SYNC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             func_clr,
    input  logic [SPD_W-1:0] spd_in,
    input  logic             spd_vld,
    input  logic             probe_in,
    input  logic             rearm_in,
    output logic [ACC_W-1:0] phase_o,
    output logic [ACC_W-1:0] cap_last_o,
    output logic [ACC_W-1:0] cap_prev_o,
    output logic             inhibit_o
);

    logic probe_rise;
    logic rearm_rise;
    logic [ACC_W-1:0] acc;

    tp_edge_sync #(.STAGES(SYNC_N)) u_probe_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (probe_in),
        .rise_o (probe_rise)
    );

    tp_edge_sync #(.STAGES(SYNC_N)) u_rearm_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (rearm_in),
        .rise_o (rearm_rise)
    );

    tp_phase_acc #(.SPD_W(SPD_W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (func_clr),
        .spd_i (spd_in),
        .vld_i (spd_vld),
        .acc_o (acc)
    );

    tp_cap_hist #(.ACC_W(ACC_W)) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (func_clr),
        .probe_rise_i (probe_rise),
        .rearm_rise_i (rearm_rise),
        .acc_i        (acc),
        .last_o       (cap_last_o),
        .prev_o       (cap_prev_o),
        .inhibit_o    (inhibit_o)
    );

    assign phase_o = acc;

    // An accepted capture always leaves the block inhibited (R5).
    assert_capture_sets_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!func_clr && !rearm_rise && probe_rise && !inhibit_o) |=> inhibit_o);

endmodule

// File: tb/tp_phase_latch_bench.sv
`timescale 1ns/1ps
module tp_phase_latch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        func_clr = 1'b0;
    logic [15:0] spd_in = '0;
    logic        spd_vld = 1'b0;
    logic        probe_in = 1'b0;
    logic        rearm_in = 1'b0;
    logic [31:0] phase_o, cap_last_o, cap_prev_o;
    logic        inhibit_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_acc = '0;
    logic [31:0] exp_last = '0;
    logic [31:0] exp_prev = '0;

    always #4 clk = ~clk;

    tp_phase_latch u_tp_phase_latch (
        .clk(clk), .rst_n(rst_n), .func_clr(func_clr),
        .spd_in(spd_in), .spd_vld(spd_vld),
        .probe_in(probe_in), .rearm_in(rearm_in),
        .phase_o(phase_o), .cap_last_o(cap_last_o),
        .cap_prev_o(cap_prev_o), .inhibit_o(inhibit_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic exp_inh);
        chk(req, "phase", phase_o, exp_acc);
        chk(req, "cap_last", cap_last_o, exp_last);
        chk(req, "cap_prev", cap_prev_o, exp_prev);
        chk(req, "inhibit", {31'd0, inhibit_o}, {31'd0, exp_inh});
    endtask

    task automatic add_burst(input logic [15:0] v, input int n);
        spd_in  = v;
        spd_vld = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exp_acc = exp_acc + {{16{v[15]}}, v};
        end
        spd_vld = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic probe_pulse();
        probe_in = 1'b1;
        repeat (3) @(negedge clk);
        probe_in = 1'b0;
    endtask

    task automatic rearm_pulse();
        rearm_in = 1'b1;
        repeat (3) @(negedge clk);
        rearm_in = 1'b0;
        settle();
    endtask

    task automatic t_reset_state();
        chk_all("R9", 1'b0);
    endtask

    task automatic t_accumulate();
        add_burst(16'd100, 1);
        chk("R2", "phase after +100", phase_o, exp_acc);
        add_burst(16'hFFE2, 1);
        chk("R1", "phase after -30", phase_o, exp_acc);
        add_burst(16'h7FFF, 2);
        add_burst(16'h8000, 1);
        chk("R1", "phase after extremes", phase_o, exp_acc);
        spd_in = 16'h1234;
        repeat (3) @(negedge clk);
        chk("R1", "hold when not valid", phase_o, exp_acc);
    endtask

    task automatic t_first_capture();
        probe_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3", "no capture before third edge", cap_last_o, 32'd0);
        @(negedge clk);
        exp_prev = exp_last;
        exp_last = exp_acc;
        chk_all("R3", 1'b1);
        probe_in = 1'b0;
        settle();
    endtask

    task automatic t_inhibited();
        add_burst(16'd500, 3);
        probe_pulse();
        settle();
        chk_all("R5", 1'b1);
    endtask

    task automatic t_rearm_steady();
        rearm_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "inhibit cleared by rearm edge", {31'd0, inhibit_o}, 32'd0);
        add_burst(16'hFF00, 2);
        probe_pulse();
        exp_prev = exp_last;
        exp_last = exp_acc;
        chk_all("R4", 1'b1);
        add_burst(16'd7, 1);
        probe_pulse();
        repeat (5) @(negedge clk);
        chk_all("R6", 1'b1);
        rearm_in = 1'b0;
        settle();
    endtask

    task automatic t_coincident();
        rearm_pulse();
        chk("R7", "armed before coincident edges", {31'd0, inhibit_o}, 32'd0);
        add_burst(16'd42, 1);
        probe_in = 1'b1;
        rearm_in = 1'b1;
        repeat (3) @(negedge clk);
        probe_in = 1'b0;
        rearm_in = 1'b0;
        settle();
        chk_all("R7", 1'b0);
        probe_pulse();
        exp_prev = exp_last;
        exp_last = exp_acc;
        chk_all("R7", 1'b1);
        settle();
    endtask

    task automatic t_clear_single();
        func_clr = 1'b1;
        spd_in   = 16'd9;
        spd_vld  = 1'b1;
        @(negedge clk);
        func_clr = 1'b0;
        spd_vld  = 1'b0;
        exp_acc = '0; exp_last = '0; exp_prev = '0;
        chk_all("R8", 1'b0);
    endtask

    task automatic t_clear_vs_capture();
        add_burst(16'd77, 2);
        func_clr = 1'b1;
        probe_in = 1'b1;
        repeat (4) @(negedge clk);
        func_clr = 1'b0;
        exp_acc = '0;
        repeat (3) @(negedge clk);
        chk_all("R8", 1'b0);
        probe_in = 1'b0;
        settle();
    endtask

    task automatic t_wrap();
        add_burst(16'h7FFF, 65538);
        chk("R1", "near positive limit", phase_o, 32'h7FFF_FFFE);
        add_burst(16'h7FFF, 1);
        chk("R1", "wrapped past positive limit", phase_o, 32'h8000_7FFD);
        probe_pulse();
        exp_prev = exp_last;
        exp_last = exp_acc;
        chk_all("R3", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_accumulate();
        t_first_capture();
        t_inhibited();
        t_rearm_steady();
        t_coincident();
        t_clear_single();
        t_clear_vs_capture();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule